// File: doc/BRIEF.md
# Locked Legacy Configuration Port

This block is the configuration front end of a legacy I/O-mapped controller. It starts up locked and watches byte writes to one fixed base port. Only a four-byte key written to that port opens it. While it is open, software selects an internal register by writing a register number to the base port, then reads or writes the register through the port one above the base. A write of the exit code to the exit register closes the unit again.

Behind the port pair are three kinds of register:
- global registers, which include a read-only two-byte chip identifier and a flash-control register;
- a device-select register;
- a banked pair of registers that hold a 16-bit flash controller I/O base. This pair exists only when device 7 is selected.

The stored flash base and flash-control bits are always driven on output ports, so downstream logic can use them whether the unit is locked or not.

The host side is a plain strobe bus. `io_wr` and `io_rd` are single-cycle requests with no back-pressure, and every access completes in one cycle. A read answer appears on `io_rdata` with `io_rvalid` high in the cycle after the request. An access whose address is neither the base port nor base+1 is ignored and produces no `io_rvalid`.

Top module: `cfg_port_unit`

## Requirements
- R1: After reset the unit is locked (`unlocked`=0), `flash_base` equals parameter `FBASE_RST`, `flash_ctl` is 0, and a read at base+1 returns 0xFF.
- R2: Writing 0x87, 0x01, 0x55 and then the final key byte to the base port sets `unlocked` in the cycle after the fourth write.
- R3: The final key byte is 0xAA when `BASE_PORT` is 0x4E and 0x55 for any other base, so 0x55 does not unlock a unit at 0x4E.
- R4: While locked, any base-port write that does not continue the key sends the matcher back to its start. A stray 0x87 restarts the matcher as if 0x87 were the first key byte, so 0x87 0x87 0x01 0x55 0x55 unlocks and 0x87 0x01 0x00 0x55 0x55 does not.
- R5: Accesses are decoded only at `BASE_PORT` (register index) and `BASE_PORT`+1 (register data), with each answer arriving one cycle after `io_rd`. All other addresses are ignored. While unlocked, a read of the base port returns the current index.
- R6: Register 0x20 reads 0x87 and register 0x21 reads 0x16. Writes to either are ignored.
- R7: Writing 0x02 to register 0x02 relocks the unit. Any other value written there has no effect. Register 0x02 reads 0x00.
- R8: Register 0x07 holds the selected device number (read/write). With device 7 selected, registers 0x64 and 0x65 hold the high and low bytes of `flash_base`. With any other device selected, those registers read 0x00 and writes to them are ignored.
- R9: Register 0x24 stores bits 5:0 (bit 0 suspend, bits 1 to 3 segment enables, bit 4 bus write enable, bit 5 pin assignment select). Bits 7:6 read 0, and bits 5:0 drive `flash_ctl`.
- R10: While locked, data-port reads return 0xFF and data-port writes change nothing, while `flash_base` and `flash_ctl` keep their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | ADDR_W | I/O address of the current access |
| io_wr | input | 1 | Single-cycle write strobe |
| io_rd | input | 1 | Single-cycle read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data, valid when `io_rvalid` is high |
| io_rvalid | output | 1 | High for one cycle after a decoded read |
| unlocked | output | 1 | Configuration mode is open |
| flash_base | output | 16 | Stored flash controller I/O base |
| flash_ctl | output | FCTL_W | Stored flash-control bits |

## Verification
The assertions assume the host never raises `io_rd` and `io_wr` in the same cycle, and that each strobe lasts exactly one cycle. The bench drives every request from a task that raises a single strobe at the falling edge and drops it one cycle later, so those assumptions hold throughout. The checks on the relock path and on the key tail also assume that the write data is stable while its strobe is high, and the tasks keep it so.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam logic [7:0] KEY_B0   = 8'h87;
  localparam logic [7:0] KEY_B1   = 8'h01;
  localparam logic [7:0] KEY_B2   = 8'h55;
  localparam logic [7:0] KEY_END0 = 8'h55;
  localparam logic [7:0] KEY_END1 = 8'hAA;

  localparam logic [7:0] REG_EXIT = 8'h02;
  localparam logic [7:0] VAL_EXIT = 8'h02;
  localparam logic [7:0] REG_DEV  = 8'h07;
  localparam logic [7:0] REG_IDHI = 8'h20;
  localparam logic [7:0] REG_IDLO = 8'h21;
  localparam logic [7:0] REG_FCTL = 8'h24;
  localparam logic [7:0] REG_FBHI = 8'h64;
  localparam logic [7:0] REG_FBLO = 8'h65;

  localparam logic [7:0] ID_HI = 8'h87;
  localparam logic [7:0] ID_LO = 8'h16;

  typedef enum logic [1:0] {
    KS_START = 2'd0,
    KS_SEEN1 = 2'd1,
    KS_SEEN2 = 2'd2,
    KS_SEEN3 = 2'd3
  } key_step_e;
endpackage

// File: rtl/cfg_key_matcher.sv
module cfg_key_matcher
  import cfg_port_pkg::*;
#(
  parameter logic [7:0] KEY_LAST = 8'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_byte,
  input  logic       relock,
  output logic       open_o
);
  key_step_e step_q, step_d;
  logic      open_d;

  always_comb begin
    step_d = step_q;
    open_d = open_o;
    if (open_o) begin
      step_d = KS_START;
      if (relock) open_d = 1'b0;
    end else if (key_we) begin
      unique case (step_q)
        KS_START: step_d = (key_byte == KEY_B0) ? KS_SEEN1 : KS_START;
        KS_SEEN1: step_d = (key_byte == KEY_B1) ? KS_SEEN2 :
                           (key_byte == KEY_B0) ? KS_SEEN1 : KS_START;
        KS_SEEN2: step_d = (key_byte == KEY_B2) ? KS_SEEN3 :
                           (key_byte == KEY_B0) ? KS_SEEN1 : KS_START;
        KS_SEEN3: begin
          if (key_byte == KEY_LAST) begin
            open_d = 1'b1;
            step_d = KS_START;
          end else begin
            step_d = (key_byte == KEY_B0) ? KS_SEEN1 : KS_START;
          end
        end
        default: step_d = KS_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= KS_START;
      open_o <= 1'b0;
    end else begin
      step_q <= step_d;
      open_o <= open_d;
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_port_pkg::*;
#(
  parameter int          FCTL_W    = 6,
  parameter logic [7:0]  FLASH_DEV = 8'h07,
  parameter logic [15:0] FBASE_RST = 16'h0820
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [7:0]        wdata,
  output logic [7:0]        idx_o,
  output logic [7:0]        rd_val,
  output logic              relock_req,
  output logic [15:0]       fbase_o,
  output logic [FCTL_W-1:0] fctl_o
);
  localparam int PAD_W = 8 - FCTL_W;

  logic [7:0] dev_q;
  logic       flash_dev_sel;

  assign flash_dev_sel = (dev_q == FLASH_DEV);
  assign relock_req    = dat_we && (idx_o == REG_EXIT) && (wdata == VAL_EXIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o   <= 8'h00;
      dev_q   <= 8'h00;
      fctl_o  <= '0;
      fbase_o <= FBASE_RST;
    end else begin
      if (idx_we) idx_o <= wdata;
      if (dat_we) begin
        unique case (idx_o)
          REG_DEV:  dev_q  <= wdata;
          REG_FCTL: fctl_o <= wdata[FCTL_W-1:0];
          REG_FBHI: if (flash_dev_sel) fbase_o[15:8] <= wdata;
          REG_FBLO: if (flash_dev_sel) fbase_o[7:0]  <= wdata;
          default: ;
        endcase
      end
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        unique case (idx_o)
          REG_DEV:  rd_val = dev_q;
          REG_IDHI: rd_val = ID_HI;
          REG_IDLO: rd_val = ID_LO;
          REG_FCTL: rd_val = {{PAD_W{1'b0}}, fctl_o};
          REG_FBHI: rd_val = flash_dev_sel ? fbase_o[15:8] : 8'h00;
          REG_FBLO: rd_val = flash_dev_sel ? fbase_o[7:0]  : 8'h00;
          default:  rd_val = 8'h00;
        endcase
      end
    end else begin : g_nopad
      always_comb begin
        unique case (idx_o)
          REG_DEV:  rd_val = dev_q;
          REG_IDHI: rd_val = ID_HI;
          REG_IDLO: rd_val = ID_LO;
          REG_FCTL: rd_val = fctl_o[7:0];
          REG_FBHI: rd_val = flash_dev_sel ? fbase_o[15:8] : 8'h00;
          REG_FBLO: rd_val = flash_dev_sel ? fbase_o[7:0]  : 8'h00;
          default:  rd_val = 8'h00;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_port_unit.sv
module cfg_port_unit
  import cfg_port_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_PORT = 16'h002E,
  parameter int          FCTL_W    = 6,
  parameter logic [15:0] FBASE_RST = 16'h0820
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rvalid,
  output logic              unlocked,
  output logic [15:0]       flash_base,
  output logic [FCTL_W-1:0] flash_ctl
);
  localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_PORT) + ADDR_W'(1);
  localparam logic [7:0]        KEY_LAST = (BASE_PORT == 16'h004E) ? KEY_END1 : KEY_END0;

  logic       hit_idx, hit_dat;
  logic       relock_req;
  logic [7:0] cur_idx, reg_val;

  assign hit_idx = (io_addr == IDX_PORT);
  assign hit_dat = (io_addr == DAT_PORT);

  cfg_key_matcher #(.KEY_LAST(KEY_LAST)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (io_wr && hit_idx && !unlocked),
    .key_byte (io_wdata),
    .relock   (relock_req),
    .open_o   (unlocked)
  );

  cfg_reg_bank #(
    .FCTL_W    (FCTL_W),
    .FLASH_DEV (8'h07),
    .FBASE_RST (FBASE_RST)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx_we     (io_wr && hit_idx && unlocked),
    .dat_we     (io_wr && hit_dat && unlocked),
    .wdata      (io_wdata),
    .idx_o      (cur_idx),
    .rd_val     (reg_val),
    .relock_req (relock_req),
    .fbase_o    (flash_base),
    .fctl_o     (flash_ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rdata  <= 8'hFF;
      io_rvalid <= 1'b0;
    end else begin
      io_rvalid <= io_rd && (hit_idx || hit_dat);
      if (io_rd && (hit_idx || hit_dat)) begin
        if (!unlocked)    io_rdata <= 8'hFF;
        else if (hit_dat) io_rdata <= reg_val;
        else              io_rdata <= cur_idx;
      end
    end
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_PORT = 16'h002E,
  parameter int          FCTL_W    = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              io_rvalid,
  input logic              unlocked,
  input logic [15:0]       flash_base,
  input logic [FCTL_W-1:0] flash_ctl,
  input logic [7:0]        cur_idx
);
  localparam logic [ADDR_W-1:0] P0 = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] P1 = ADDR_W'(BASE_PORT) + ADDR_W'(1);
  localparam logic [7:0]        LAST_B = (BASE_PORT == 16'h004E) ? 8'hAA : 8'h55;

  // R2
  unlock_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(io_wr && io_addr == P0 && io_wdata == LAST_B));

  // R10
  locked_base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(flash_base) && $stable(flash_ctl)));

  // R10
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == P1 && !unlocked) |=> (io_rvalid && io_rdata == 8'hFF));

  // R5
  rvalid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd && (io_addr == P0 || io_addr == P1)));

  // R7
  exit_relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && io_wr && io_addr == P1 && cur_idx == 8'h02 && io_wdata == 8'h02)
      |=> !unlocked);
endmodule

bind cfg_port_unit cfg_port_chk #(
  .ADDR_W    (ADDR_W),
  .BASE_PORT (BASE_PORT),
  .FCTL_W    (FCTL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_wdata   (io_wdata),
  .io_rdata   (io_rdata),
  .io_rvalid  (io_rvalid),
  .unlocked   (unlocked),
  .flash_base (flash_base),
  .flash_ctl  (flash_ctl),
  .cur_idx    (cur_idx)
);

// File: tb/test_cfg_port_unit.sv
module test_cfg_port_unit;
  localparam logic [15:0] P_IDX = 16'h002E;
  localparam logic [15:0] P_DAT = 16'h002F;
  localparam logic [15:0] Q_IDX = 16'h004E;
  localparam logic [15:0] RST_FB = 16'h0820;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  rdata_a, rdata_b;
  logic        rvalid_a, rvalid_b, unl_a, unl_b;
  logic [15:0] fbase_a, fbase_b;
  logic [5:0]  fctl_a, fctl_b;

  int n_run = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  cfg_port_unit #(.BASE_PORT(16'h002E), .FBASE_RST(RST_FB)) i_cfg_port_unit (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata_a), .io_rvalid(rvalid_a),
    .unlocked(unl_a), .flash_base(fbase_a), .flash_ctl(fctl_a));

  cfg_port_unit #(.BASE_PORT(16'h004E), .FBASE_RST(RST_FB)) i_cfg_port_unit_alt (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(rdata_b), .io_rvalid(rvalid_b),
    .unlocked(unl_b), .flash_base(fbase_b), .flash_ctl(fctl_b));

  // entry: {req[3:0], is_rd, is_data_port, wdata[7:0], expect[7:0]}
  localparam int NV = 37;
  localparam logic [21:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 8'h87, 8'h00},  // R2 key
    {4'd2, 1'b0, 1'b0, 8'h01, 8'h00},
    {4'd2, 1'b0, 1'b0, 8'h55, 8'h00},
    {4'd2, 1'b0, 1'b0, 8'h55, 8'h00},
    {4'd6, 1'b0, 1'b0, 8'h20, 8'h00},  // R6 id high
    {4'd6, 1'b1, 1'b1, 8'h00, 8'h87},
    {4'd6, 1'b0, 1'b0, 8'h21, 8'h00},
    {4'd6, 1'b1, 1'b1, 8'h00, 8'h16},
    {4'd6, 1'b0, 1'b1, 8'h55, 8'h00},  // R6 write ignored
    {4'd6, 1'b1, 1'b1, 8'h00, 8'h16},
    {4'd8, 1'b0, 1'b0, 8'h07, 8'h00},  // R8 device select
    {4'd8, 1'b0, 1'b1, 8'h07, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h07},
    {4'd8, 1'b0, 1'b0, 8'h64, 8'h00},
    {4'd8, 1'b0, 1'b1, 8'hA5, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'hA5},
    {4'd8, 1'b0, 1'b0, 8'h65, 8'h00},
    {4'd8, 1'b0, 1'b1, 8'h3C, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h3C},
    {4'd8, 1'b0, 1'b0, 8'h07, 8'h00},  // R8 other device
    {4'd8, 1'b0, 1'b1, 8'h03, 8'h00},
    {4'd8, 1'b0, 1'b0, 8'h64, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd8, 1'b0, 1'b1, 8'h11, 8'h00},
    {4'd8, 1'b0, 1'b0, 8'h07, 8'h00},
    {4'd8, 1'b0, 1'b1, 8'h07, 8'h00},
    {4'd8, 1'b0, 1'b0, 8'h64, 8'h00},
    {4'd8, 1'b1, 1'b1, 8'h00, 8'hA5},  // R8 write under device 3 ignored
    {4'd9, 1'b0, 1'b0, 8'h24, 8'h00},  // R9 flash control
    {4'd9, 1'b0, 1'b1, 8'hFF, 8'h00},
    {4'd9, 1'b1, 1'b1, 8'h00, 8'h3F},
    {4'd5, 1'b1, 1'b0, 8'h00, 8'h24},  // R5 index readback
    {4'd7, 1'b0, 1'b0, 8'h02, 8'h00},  // R7 exit register
    {4'd7, 1'b0, 1'b1, 8'h01, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h00, 8'h00},
    {4'd7, 1'b0, 1'b1, 8'h02, 8'h00},
    {4'd7, 1'b1, 1'b1, 8'h00, 8'hFF}   // R7 relocked, R10 reads 0xFF
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] da, output logic va,
                    output logic [7:0] db, output logic vb);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    da = rdata_a; va = rvalid_a; db = rdata_b; vb = rvalid_b;
  endtask

  task automatic key_a(input logic [7:0] b0, b1, b2, b3);
    wr(P_IDX, b0); wr(P_IDX, b1); wr(P_IDX, b2); wr(P_IDX, b3);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin : main
    logic [7:0] da, db;
    logic va, vb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 unlocked", unl_a, 0);
    check("R1 flash_base", fbase_a, RST_FB);
    check("R1 flash_ctl", fctl_a, 0);
    rd(P_DAT, da, va, db, vb);
    check("R1 read", {va, da}, {1'b1, 8'hFF});

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      logic [15:0] a;
      string tag;
      v = VEC[i];
      a = v[16] ? P_DAT : P_IDX;
      tag = $sformatf("R%0d vec%0d", v[21:18], i);
      if (v[17]) begin
        rd(a, da, va, db, vb);
        check(tag, {va, da}, {1'b1, v[7:0]});
      end else begin
        wr(a, v[15:8]);
      end
    end

    // R10 outputs keep values while locked, data writes ignored
    check("R10 locked", unl_a, 0);
    check("R10 flash_base", fbase_a, 16'hA53C);
    check("R10 flash_ctl", fctl_a, 6'h3F);
    wr(P_DAT, 8'h00);
    check("R10 flash_base after write", fbase_a, 16'hA53C);
    key_a(8'h87, 8'h01, 8'h55, 8'h55);
    wr(P_IDX, 8'h64);
    rd(P_DAT, da, va, db, vb);
    check("R10 reg kept", da, 8'hA5);
    wr(P_IDX, 8'h02); wr(P_DAT, 8'h02);

    // R4 broken sequence does not unlock
    wr(P_IDX, 8'h87); key_a(8'h01, 8'h00, 8'h55, 8'h55);
    check("R4 broken", unl_a, 0);
    rd(P_DAT, da, va, db, vb);
    check("R4 broken read", da, 8'hFF);
    // R4 repeated 0x87 restarts at step two
    wr(P_IDX, 8'h87); key_a(8'h87, 8'h01, 8'h55, 8'h55);
    check("R4 restart", unl_a, 1);
    wr(P_IDX, 8'h02); wr(P_DAT, 8'h02);
    check("R7 exit", unl_a, 0);

    // R5 other unit's port ignored, R3 alternate final byte
    check("R5 alt stays locked", unl_b, 0);
    wr(Q_IDX, 8'h87); wr(Q_IDX, 8'h01); wr(Q_IDX, 8'h55); wr(Q_IDX, 8'h55);
    check("R3 0x55 rejected", unl_b, 0);
    check("R5 main ignores other port", unl_a, 0);
    wr(Q_IDX, 8'h87); wr(Q_IDX, 8'h01); wr(Q_IDX, 8'h55); wr(Q_IDX, 8'hAA);
    check("R3 0xAA accepted", unl_b, 1);
    wr(Q_IDX, 8'h21);
    rd(16'h004F, da, va, db, vb);
    check("R3 alt id read", {vb, db}, {1'b1, 8'h16});
    check("R5 no rvalid off-port", va, 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule